// File: doc/BRIEF.md
# Rotate-Mask-Shift Unit

This block is the bit-manipulation slice of a 32-bit integer datapath. It takes a source word and rotates it left by an amount given either as a 5-bit immediate or as the low bits of a register operand. It then keeps only the bits inside a mask that is described by two indices. The same datapath also performs logical left and right shifts, an arithmetic right shift that copies the sign bit, and a leading-zero count. A rotate-and-insert variant merges the rotated bits into a prior destination value wherever the mask is clear.

Mask indices count from the most significant bit, which is index 0. The mask is inclusive at both ends. When the begin index is greater than the end index, the run of ones wraps past the least significant bit. A record-enable input asks for negative, positive and zero flags taken from the signed result. One operation may be issued per clock. The result appears one cycle later from output registers, with a matching valid strobe.

Top module: `rms_unit`

## Requirements
- R1: Operation code 0 (rotate-and-mask) returns the source rotated left by the amount, ANDed with a mask. For begin <= end, the mask has ones at most-significant-first indices begin through end inclusive: little-endian bits 31-begin down to 31-end.
- R2: When the begin index is greater than the end index, the mask holds ones from begin to index 31 and from index 0 to end, and zeros elsewhere.
- R3: For rotate-and-mask, rotate-and-insert and arithmetic right shift, the amount is the 5-bit immediate when use_imm is 1. Otherwise it is bits [4:0] of the register operand, and bits [31:5] have no effect.
- R4: A rotate amount of 0 with a full mask (begin 0, end 31) returns the source unchanged.
- R5: Operation code 1 (rotate-and-insert) returns the rotated bits where the mask is 1 and the bits of old_dst where the mask is 0.
- R6: Operation code 2 shifts left and code 3 shifts right logically, filling with zeros. Both always take the amount from register bits [4:0] and ignore the immediate.
- R7: Operation code 4 shifts right arithmetically, filling the vacated upper bits with source bit 31.
- R8: Operation code 5 returns the number of leading zero bits of the source, counted from bit 31, and returns 32 for a zero source.
- R9: With rec_en set, flag_neg is result bit 31, flag_zero is set for a zero result, and flag_pos is set for a nonzero result with bit 31 clear. At most one of the three is set.
- R10: With rec_en clear, all three flags are 0 for that result.
- R11: Reset clears out_valid, result and the flags. An operation presented with in_valid in one cycle produces its result and out_valid at the next rising clock edge. Without in_valid, out_valid is 0 in the following cycle.
- R12: Operation codes 6 and 7 yield a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (0 rotate-mask, 1 rotate-insert, 2 shift left, 3 shift right, 4 arithmetic right, 5 leading zeros) |
| src | input | 32 | Source word |
| old_dst | input | 32 | Prior destination value for rotate-and-insert |
| amt_reg | input | 32 | Register operand supplying the amount in bits [4:0] |
| amt_imm | input | 5 | Immediate amount |
| use_imm | input | 1 | Take the amount from amt_imm (rotate ops and arithmetic shift) |
| mask_beg | input | 5 | Mask begin index, most significant bit is 0 |
| mask_end | input | 5 | Mask end index, inclusive |
| rec_en | input | 1 | Compute result flags |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Result word |
| flag_neg | output | 1 | Result is negative |
| flag_pos | output | 1 | Result is positive |
| flag_zero | output | 1 | Result is zero |

## Verification
Rotate-and-mask is tried with ordinary runs, wrapping runs and single-bit runs of the mask. These patterns separate a correct wrap decision from one that only handles begin <= end, and they expose reversed bit numbering. Register amounts carry garbage in their upper bits, and the immediate differs from the register amount, so a wrong amount source gives a visibly different result. Shift amounts of 0 and 31 and sources with the sign bit set separate logical from arithmetic fill. Leading-zero counts for zero, for bit 31 alone and for bit 0 alone cover both ends of the count. A long run of varied operations then compares every result and flag against an independent bit-by-bit model.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [2:0] {
    OP_ROTAND = 3'd0,
    OP_ROTINS = 3'd1,
    OP_SHL    = 3'd2,
    OP_SHR    = 3'd3,
    OP_SRA    = 3'd4,
    OP_CLZ    = 3'd5
  } rms_op_e;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
  } rms_flags_t;
endpackage

// File: rtl/rms_rotl.sv
// Logarithmic left rotator: one stage per amount bit.
module rms_rotl #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];
  assign stg[0] = din;
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][W-1-SH:0], stg[s][W-1:W-SH]} : stg[s];
  end
  assign dout = stg[SW];
endmodule

// File: rtl/rms_mask.sv
// Builds an inclusive run of ones between two most-significant-first indices,
// wrapping past the last index when begin exceeds end.
module rms_mask #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [SW-1:0] beg,
  input  logic [SW-1:0] fin,
  output logic [W-1:0]  mask
);
  logic wraps;
  assign wraps = beg > fin;
  for (genvar k = 0; k < W; k++) begin : g_bit
    localparam logic [SW-1:0] K = SW'(k);
    logic ge_b, le_e;
    assign ge_b = K >= beg;
    assign le_e = K <= fin;
    assign mask[W-1-k] = wraps ? (ge_b | le_e) : (ge_b & le_e);
  end
endmodule

// File: rtl/rms_clz.sv
// Leading-zero counter; an all-zero word counts W.
module rms_clz #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0] din,
  output logic [SW:0]  count
);
  always_comb begin
    count = (SW+1)'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) count = (SW+1)'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rms_unit.sv
module rms_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [W-1:0]         src,
  input  logic [W-1:0]         old_dst,
  input  logic [W-1:0]         amt_reg,
  input  logic [$clog2(W)-1:0] amt_imm,
  input  logic                 use_imm,
  input  logic [$clog2(W)-1:0] mask_beg,
  input  logic [$clog2(W)-1:0] mask_end,
  input  logic                 rec_en,
  output logic                 out_valid,
  output logic [W-1:0]         result,
  output logic                 flag_neg,
  output logic                 flag_pos,
  output logic                 flag_zero
);
  import rms_pkg::*;
  localparam int SW = $clog2(W);
  localparam logic [SW-1:0] TOP_IDX = SW'(W - 1);

  rms_op_e       op_e;
  logic [SW-1:0] reg_amt, sel_amt, shamt, rot_amt, m_beg, m_end;
  logic [W-1:0]  rotated, mask, res;
  logic [SW:0]   lz;
  rms_flags_t    flg;

  assign op_e    = rms_op_e'(op);
  assign reg_amt = amt_reg[SW-1:0];
  assign sel_amt = use_imm ? amt_imm : reg_amt;

  // Shifts are rotations with a mask that trims the wrapped-around bits.
  always_comb begin
    shamt   = sel_amt;
    rot_amt = sel_amt;
    m_beg   = mask_beg;
    m_end   = mask_end;
    case (op_e)
      OP_SHL: begin
        shamt   = reg_amt;
        rot_amt = reg_amt;
        m_beg   = '0;
        m_end   = TOP_IDX - reg_amt;
      end
      OP_SHR: begin
        shamt   = reg_amt;
        rot_amt = SW'(0) - reg_amt;
        m_beg   = reg_amt;
        m_end   = TOP_IDX;
      end
      OP_SRA: begin
        rot_amt = SW'(0) - sel_amt;
        m_beg   = sel_amt;
        m_end   = TOP_IDX;
      end
      default: ;
    endcase
  end

  rms_rotl #(.W(W), .SW(SW)) u_rot  (.din(src), .amt(rot_amt), .dout(rotated));
  rms_mask #(.W(W), .SW(SW)) u_mask (.beg(m_beg), .fin(m_end), .mask(mask));
  rms_clz  #(.W(W), .SW(SW)) u_clz  (.din(src), .count(lz));

  always_comb begin
    case (op_e)
      OP_ROTAND,
      OP_SHL,
      OP_SHR:    res = rotated & mask;
      OP_ROTINS: res = (rotated & mask) | (old_dst & ~mask);
      OP_SRA:    res = (rotated & mask) | ({W{src[W-1]}} & ~mask);
      OP_CLZ:    res = W'(lz);
      default:   res = '0;
    endcase
  end

  always_comb begin
    flg.neg  = rec_en & res[W-1];
    flg.zero = rec_en & (res == '0);
    flg.pos  = rec_en & ~res[W-1] & (res != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_neg  <= 1'b0;
      flag_pos  <= 1'b0;
      flag_zero <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res;
        flag_neg  <= flg.neg;
        flag_pos  <= flg.pos;
        flag_zero <= flg.zero;
      end
    end
  end
endmodule

// File: rtl/rms_unit_chk.sv
module rms_unit_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [2:0]           op,
  input logic [W-1:0]         src,
  input logic [$clog2(W)-1:0] amt_imm,
  input logic                 use_imm,
  input logic [$clog2(W)-1:0] mask_beg,
  input logic [$clog2(W)-1:0] mask_end,
  input logic                 rec_en,
  input logic                 out_valid,
  input logic [W-1:0]         result,
  input logic                 flag_neg,
  input logic                 flag_pos,
  input logic                 flag_zero
);
  localparam int SW = $clog2(W);

  p_issue_latency_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({flag_neg, flag_pos, flag_zero}));
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_zero) |-> (result == '0));
  p_neg_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_neg) |-> result[W-1]);
  p_flags_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_en) |=> !(flag_neg || flag_pos || flag_zero));
  p_clz_range_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5) |=> (result <= W'(W)));
  p_rotate_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && use_imm && amt_imm == '0 && mask_beg == '0
     && mask_end == SW'(W - 1)) |=> (result == $past(src)));
endmodule

bind rms_unit rms_unit_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src(src),
  .amt_imm(amt_imm), .use_imm(use_imm), .mask_beg(mask_beg),
  .mask_end(mask_end), .rec_en(rec_en), .out_valid(out_valid),
  .result(result), .flag_neg(flag_neg), .flag_pos(flag_pos),
  .flag_zero(flag_zero)
);

// File: tb/test_rms_unit.sv
`timescale 1ns/1ps
module test_rms_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src = '0, old_dst = '0, amt_reg = '0;
  logic [4:0]  amt_imm = '0, mask_beg = '0, mask_end = '0;
  logic        use_imm = 1'b0, rec_en = 1'b0;
  logic        out_valid, flag_neg, flag_pos, flag_zero;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  logic [34:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  rms_unit #(.W(32)) i_rms_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src(src),
    .old_dst(old_dst), .amt_reg(amt_reg), .amt_imm(amt_imm),
    .use_imm(use_imm), .mask_beg(mask_beg), .mask_end(mask_end),
    .rec_en(rec_en), .out_valid(out_valid), .result(result),
    .flag_neg(flag_neg), .flag_pos(flag_pos), .flag_zero(flag_zero)
  );

  function automatic logic [31:0] m_rotl(logic [31:0] x, int n);
    logic [31:0] y = x;
    for (int i = 0; i < n; i++) y = {y[30:0], y[31]};
    return y;
  endfunction

  function automatic logic [31:0] m_mask(int b, int e);
    logic [31:0] m = '0;
    for (int k = 0; k < 32; k++)
      m[31-k] = (b <= e) ? (k >= b && k <= e) : (k >= b || k <= e);
    return m;
  endfunction

  function automatic logic [34:0] model(logic [2:0] o, logic [31:0] s,
      logic [31:0] od, logic [31:0] ar, logic [4:0] ai, logic ui,
      logic [4:0] mb, logic [4:0] me, logic re);
    logic [31:0] r, m;
    int n;
    n = ui ? int'(ai) : int'(ar[4:0]);
    m = m_mask(int'(mb), int'(me));
    case (o)
      3'd0: r = m_rotl(s, n) & m;
      3'd1: r = (m_rotl(s, n) & m) | (od & ~m);
      3'd2: r = s << ar[4:0];
      3'd3: r = s >> ar[4:0];
      3'd4: r = $unsigned($signed(s) >>> n);
      3'd5: begin
        r = 32;
        for (int i = 31; i >= 0; i--) if (s[i]) begin r = 31 - i; break; end
      end
      default: r = '0;
    endcase
    return {r, re & r[31], re & !r[31] & (r != 0), re & (r == 0)};
  endfunction

  task automatic issue(logic [2:0] o, logic [31:0] s, logic [31:0] od,
      logic [31:0] ar, logic [4:0] ai, logic ui, logic [4:0] mb,
      logic [4:0] me, logic re, string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; src = s; old_dst = od; amt_reg = ar;
    amt_imm = ai; use_imm = ui; mask_beg = mb; mask_end = me; rec_en = re;
    exp_q.push_back(model(o, s, od, ar, ai, ui, mb, me, re));
    tag_q.push_back(tag);
  endtask

  // Monitor: outputs are registered, so at a falling edge they hold the
  // result of the operation issued at the previous falling edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [34:0] got, exp;
      string tg;
      got = {result, flag_neg, flag_pos, flag_zero};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result: actual %h expected none", got);
      end else begin
        exp = exp_q.pop_front();
        tg  = tag_q.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL %s: actual res=%h npz=%b expected res=%h npz=%b",
                   tg, got[34:3], got[2:0], exp[34:3], exp[2:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;   // R11 reset state
    if (out_valid !== 1'b0 || result !== '0 ||
        {flag_neg, flag_pos, flag_zero} !== 3'b000) begin
      fails++;
      $display("FAIL R11 reset: actual v=%b res=%h expected v=0 res=0",
               out_valid, result);
    end
    rst = 1'b0;

    issue(3'd0, 32'h12345678, 0, 0, 5'd8, 1, 5'd8, 5'd23, 1, "R1 run 8..23");
    issue(3'd0, 32'hDEADBEEF, 0, 0, 5'd0, 1, 5'd5, 5'd5, 1, "R1 single bit");
    issue(3'd0, 32'hFFFFFFFF, 0, 0, 5'd0, 1, 5'd28, 5'd3, 1, "R2 wrap 28..3");
    issue(3'd0, 32'h0F0F1234, 0, 0, 5'd4, 1, 5'd31, 5'd0, 1, "R2 wrap 31..0");
    issue(3'd0, 32'h80000001, 0, 32'hFFFFFFE4, 5'd9, 0, 5'd0, 5'd31, 1, "R3 reg amt");
    issue(3'd0, 32'h80000001, 0, 32'hFFFFFFE4, 5'd3, 1, 5'd0, 5'd31, 1, "R3 imm amt");
    issue(3'd0, 32'hCAFEF00D, 0, 32'h7, 5'd0, 1, 5'd0, 5'd31, 1, "R4 rotate 0");
    issue(3'd1, 32'h000000AB, 32'h11111111, 0, 5'd8, 1, 5'd16, 5'd23, 0, "R5 insert");
    issue(3'd1, 32'hFFFFFFFF, 32'h00000000, 0, 5'd0, 1, 5'd30, 5'd1, 1, "R5 insert wrap");
    issue(3'd2, 32'h00000003, 0, 32'h00000025, 5'd0, 1, 5'd0, 5'd0, 1, "R6 shl reg low bits");
    issue(3'd2, 32'hFFFFFFFF, 0, 32'h0000001F, 5'd1, 1, 5'd0, 5'd0, 1, "R6 shl 31");
    issue(3'd3, 32'h80000000, 0, 32'hFFFFFFE4, 5'd0, 1, 5'd0, 5'd0, 1, "R6 shr");
    issue(3'd3, 32'h12345678, 0, 32'h00000000, 5'd7, 1, 5'd0, 5'd0, 1, "R6 shr 0");
    issue(3'd4, 32'h80000010, 0, 0, 5'd4, 1, 5'd0, 5'd0, 1, "R7 sra imm neg");
    issue(3'd4, 32'h80000000, 0, 32'h0000003F, 5'd0, 0, 5'd0, 5'd0, 1, "R7 sra 31");
    issue(3'd4, 32'h70000000, 0, 32'h00000004, 5'd0, 0, 5'd0, 5'd0, 1, "R7 sra pos");
    issue(3'd5, 32'h00000000, 0, 0, 5'd0, 0, 5'd0, 5'd0, 1, "R8 clz zero");
    issue(3'd5, 32'h80000000, 0, 0, 5'd0, 0, 5'd0, 5'd0, 1, "R8 clz msb");
    issue(3'd5, 32'h00000001, 0, 0, 5'd0, 0, 5'd0, 5'd0, 1, "R8 clz lsb");
    issue(3'd0, 32'h00000000, 0, 0, 5'd0, 1, 5'd0, 5'd31, 1, "R9 zero flag");
    issue(3'd0, 32'hF0000000, 0, 0, 5'd0, 1, 5'd0, 5'd31, 1, "R9 neg flag");
    issue(3'd0, 32'hF0000000, 0, 0, 5'd0, 1, 5'd0, 5'd31, 0, "R10 flags off");
    issue(3'd0, 32'h00000000, 0, 0, 5'd0, 1, 5'd0, 5'd31, 0, "R10 zero off");
    issue(3'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 5'd1, 1, 5'd0, 5'd31, 1, "R12 code 6");
    issue(3'd7, 32'h12345678, 0, 0, 5'd1, 1, 5'd0, 5'd31, 1, "R12 code 7");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 5));
      issue(o, $urandom, $urandom, $urandom, 5'($urandom), 1'($urandom),
            5'($urandom), 5'($urandom), 1'($urandom),
            o == 3'd0 ? "R1 mixed" : o == 3'd1 ? "R5 mixed" :
            o == 3'd4 ? "R7 mixed" : o == 3'd5 ? "R8 mixed" : "R6 mixed");
      if ((i % 7) == 6) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    checks++;   // R11: every issued operation produced exactly one result
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing results: actual %0d pending expected 0",
               exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule